// File: doc/BRIEF.md
# Byte-Wide SPI Master with Per-Select Register Banks

This block is a memory-mapped SPI master that moves one byte for each command. Each chip select owns a bank of four registers: status, configuration, control and data. Software prepares a byte in the data register of a select and then sets a start bit in the control register of that select. The block shifts exactly eight bits, using the clock divider, clock idle level, launch edge, sample edge and bit order taken from that select's configuration. While the byte is in flight, a busy flag is visible in every status register.

There are two commands. A write command transmits the data register and throws the received bits away. A read command also transmits the data register, and when it ends it stores the received byte in that register. Each chip-select pin is asserted by clearing the enable bit in its control register. The level of an asserted select comes from a shared arbiter register. A data-out tri-state bit in the control register sets the output enable of the serial data line while that select owns the bus.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every configuration register reads 0x153 (bit order MSB-first, idle-low clock, transmit on the falling edge, divider code 3). Every control register reads 0x9 (data-out high impedance, enable set). Status reads 0, the arbiter reads 0, all select pins are high, `spi_sck` is low and `spi_mosi_oe` is low.
- R2: Select k's bank starts at byte address 0x40*k. Within the bank, status is at +0x00, configuration at +0x10, control at +0x14 and data at +0x20. The arbiter is at 0xF0. Any other address reads 0. A write to one bank does not change another bank.
- R3: Setting control bit 2 (start write) begins a command that shifts the low byte of that select's data register onto `spi_mosi`. Status bit 0 is 1 while the command runs. The data register is unchanged at the end of the command.
- R4: Setting control bit 1 (start read) also shifts out the data register. When the command ends, the eight bits sampled from `spi_miso` replace that select's data register.
- R5: Configuration bit 8 selects the bit order. When it is 1, the MSB goes on the wire first and the first bit received lands in bit 7. When it is 0, the LSB goes first and the first bit received lands in bit 0.
- R6: Configuration bit 6 set makes the idle clock level low; cleared makes it high. Bit 4 set moves data out on falling clock edges (rising when clear). Bit 5 set samples `spi_miso` on falling edges (rising when clear). Data out holds steady between launch edges. The four standard SPI modes map to the register values 0x50, 0x60, 0x20 and 0x10.
- R7: For a divider code p from 0 to 6, the clock toggles every 2^p system cycles. Status busy stays 1 for exactly 16*2^p cycles after the control write.
- R8: Divider code 7 stops the clock. A started command stays busy with no clock edges. Once the code is rewritten to a running value, the command continues and completes.
- R9: A start request made while busy is ignored: no second command runs and the data register is not captured. Start bits always read back as 0. If both start bits are set together, the command is a write.
- R10: Select pin k is asserted when control bit 0 of bank k is 0. Its asserted level is arbiter bit k (1 means active high). The deasserted level is the opposite. Arbiter bit 31 is stored and read back.
- R11: `spi_mosi_oe` is the inverse of control bit 3 of the select that most recently started a command (select 0 after reset).
- R12: Each command produces exactly 16 clock edges, and the clock rests at its idle level afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 2 | Chip-select pins, one per select |

## Verification
The assertions assume that while a command runs, software rewrites only the divider field of the owning select's configuration. The clock level and data-out hold properties depend on that configuration staying fixed. The bench keeps to this: during a command it only rewrites the divider, in the stopped-clock scenario. The bench slave changes `spi_miso` only on launch edges, so the sampled bit never moves in the cycle the master samples it. Only the four standard edge combinations are driven.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  localparam int PRESC_W = 3;
  localparam int DIV_W   = (1 << PRESC_W) - 2;
  localparam logic [PRESC_W-1:0] PRESC_STOP = '1;

  localparam logic [5:0] OFF_STAT = 6'h00;
  localparam logic [5:0] OFF_CFG  = 6'h10;
  localparam logic [5:0] OFF_CTL  = 6'h14;
  localparam logic [5:0] OFF_DATA = 6'h20;
  localparam logic [7:0] ARB_ADDR = 8'hF0;

  typedef struct packed {
    logic               msb_first;
    logic               idle_low;
    logic               rx_fall;
    logic               tx_fall;
    logic [PRESC_W-1:0] presc;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{1'b1, 1'b1, 1'b0, 1'b1, 3'd3};

  function automatic cfg_t cfg_unpack(input logic [31:0] w);
    cfg_t c;
    c.msb_first = w[8];
    c.idle_low  = w[6];
    c.rx_fall   = w[5];
    c.tx_fall   = w[4];
    c.presc     = w[PRESC_W-1:0];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input cfg_t c);
    logic [31:0] w;
    w = 32'h0;
    w[8] = c.msb_first;
    w[6] = c.idle_low;
    w[5] = c.rx_fall;
    w[4] = c.tx_fall;
    w[PRESC_W-1:0] = c.presc;
    return w;
  endfunction

  // last count value of one half clock period: 2^p - 1 system cycles
  function automatic logic [DIV_W-1:0] half_last(input logic [PRESC_W-1:0] p);
    int unsigned h;
    h = (32'd1 << p) - 32'd1;
    return h[DIV_W-1:0];
  endfunction

  // serial clock level for a given half-period phase
  function automatic logic sck_level(input logic idle_low, input logic phase);
    return (~idle_low) ^ phase;
  endfunction

endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
  import spi_bm_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              cmd_start,
  output logic [DATA_W-1:0] tx_byte,
  output cfg_t              cur_cfg,
  output logic              cur_hiz,
  output logic [NUM_CS-1:0] cs_act,
  output logic [NUM_CS-1:0] cs_pol
);

  localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int BANK_W = ADDR_W - 6;

  logic [BANK_W-1:0] bank;
  logic [5:0]        off;
  logic              bank_ok;
  logic [SEL_W-1:0]  bsel;
  logic [SEL_W-1:0]  sel_q;
  logic              rd_q;
  logic              arb_en_q;
  logic [NUM_CS-1:0] pol_q;
  logic              capture;

  cfg_t              cfg_q  [NUM_CS];
  logic              en_q   [NUM_CS];
  logic              hiz_q  [NUM_CS];
  logic [DATA_W-1:0] data_q [NUM_CS];

  assign bank    = reg_addr[ADDR_W-1:6];
  assign off     = reg_addr[5:0];
  assign bank_ok = (int'(bank) < NUM_CS) && (reg_addr != ARB_ADDR);
  assign bsel    = bank[SEL_W-1:0];

  assign cmd_start = reg_wr && bank_ok && (off == OFF_CTL) &&
                     (reg_wdata[2] || reg_wdata[1]) && !busy;
  assign capture   = done && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      rd_q  <= 1'b0;
    end else if (cmd_start) begin
      sel_q <= bsel;
      rd_q  <= !reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_en_q <= 1'b0;
      pol_q    <= '0;
    end else if (reg_wr && reg_addr == ARB_ADDR) begin
      arb_en_q <= reg_wdata[31];
      pol_q    <= reg_wdata[NUM_CS-1:0];
    end
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_bank
    logic wr_here;
    assign wr_here = reg_wr && bank_ok && (bsel == SEL_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[k] <= CFG_RESET;
        en_q[k]  <= 1'b1;
        hiz_q[k] <= 1'b1;
      end else if (wr_here && off == OFF_CFG) begin
        cfg_q[k] <= cfg_unpack(reg_wdata);
      end else if (wr_here && off == OFF_CTL) begin
        en_q[k]  <= reg_wdata[0];
        hiz_q[k] <= reg_wdata[3];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[k] <= '0;
      end else if (capture && sel_q == SEL_W'(k)) begin
        data_q[k] <= rx_byte;
      end else if (wr_here && off == OFF_DATA) begin
        data_q[k] <= reg_wdata[DATA_W-1:0];
      end
    end

    assign cs_act[k] = !en_q[k];
  end

  assign cs_pol  = pol_q;
  assign tx_byte = data_q[bsel];
  assign cur_cfg = cfg_q[sel_q];
  assign cur_hiz = hiz_q[sel_q];

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr == ARB_ADDR) begin
      reg_rdata[31]         = arb_en_q;
      reg_rdata[NUM_CS-1:0] = pol_q;
    end else if (bank_ok) begin
      case (off)
        OFF_STAT: reg_rdata[0] = busy;
        OFF_CFG:  reg_rdata = cfg_pack(cfg_q[bsel]);
        OFF_CTL:  reg_rdata = {28'h0, hiz_q[bsel], 2'b00, en_q[bsel]};
        OFF_DATA: reg_rdata[DATA_W-1:0] = data_q[bsel];
        default:  reg_rdata = 32'h0;
      endcase
    end
  end

endmodule

// File: rtl/spi_bm_clkgen.sv
module spi_bm_clkgen
  import spi_bm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             stopped;
  logic             at_end;

  assign stopped = (presc == PRESC_STOP);
  assign at_end  = (cnt_q >= half_last(presc));
  assign tick    = run && !stopped && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || stopped)  cnt_q <= '0;
    else if (at_end)           cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  cfg_t              cfg,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sample_evt,
  output logic              launch_evt,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic              busy_q;
  logic              phase_q;
  logic              sampled_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] rx_next;
  logic              next_lvl;

  assign next_lvl   = sck_level(cfg.idle_low, !phase_q);
  assign sample_evt = tick && (cfg.rx_fall ? !next_lvl : next_lvl);
  assign launch_evt = tick && (cfg.tx_fall ? !next_lvl : next_lvl);
  assign done       = tick && (edge_q == EDGE_W'(EDGES - 1));

  always_comb begin
    rx_next = rx_q;
    if (sample_evt) begin
      if (cfg.msb_first) rx_next = {rx_q[DATA_W-2:0], miso};
      else               rx_next = {miso, rx_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      phase_q   <= 1'b0;
      sampled_q <= 1'b0;
      edge_q    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else if (start && !busy_q) begin
      busy_q    <= 1'b1;
      phase_q   <= 1'b0;
      sampled_q <= 1'b0;
      edge_q    <= '0;
      tx_q      <= tx_byte;
      rx_q      <= '0;
    end else if (tick) begin
      phase_q <= !phase_q;
      edge_q  <= edge_q + 1'b1;
      rx_q    <= rx_next;
      if (sample_evt) sampled_q <= 1'b1;
      // the first launch edge before any sample keeps the preloaded bit
      if (launch_evt && sampled_q) begin
        if (cfg.msb_first) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        else               tx_q <= {1'b0, tx_q[DATA_W-1:1]};
      end
      if (done) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign rx_byte = rx_next;
  assign sck     = sck_level(cfg.idle_low, phase_q);
  assign mosi    = cfg.msb_first ? tx_q[DATA_W-1] : tx_q[0];

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs
);

  logic              busy_w;
  logic              cmd_start;
  logic              cmd_done;
  logic              tick;
  logic              sample_evt;
  logic              launch_evt;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] rx_byte;
  cfg_t              cur_cfg;
  logic              cur_hiz;
  logic [NUM_CS-1:0] cs_act;
  logic [NUM_CS-1:0] cs_pol;

  spi_bm_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy_w),
    .done      (cmd_done),
    .rx_byte   (rx_byte),
    .cmd_start (cmd_start),
    .tx_byte   (tx_byte),
    .cur_cfg   (cur_cfg),
    .cur_hiz   (cur_hiz),
    .cs_act    (cs_act),
    .cs_pol    (cs_pol)
  );

  spi_bm_clkgen i_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_w),
    .presc (cur_cfg.presc),
    .tick  (tick)
  );

  spi_bm_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cmd_start),
    .tx_byte    (tx_byte),
    .cfg        (cur_cfg),
    .tick       (tick),
    .miso       (spi_miso),
    .busy       (busy_w),
    .done       (cmd_done),
    .sample_evt (sample_evt),
    .launch_evt (launch_evt),
    .rx_byte    (rx_byte),
    .sck        (spi_sck),
    .mosi       (spi_mosi)
  );

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign spi_cs[k] = cs_act[k] ? cs_pol[k] : !cs_pol[k];
  end

  assign spi_mosi_oe = !cur_hiz;

endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic cmd_start,
  input logic cmd_done,
  input logic tick,
  input logic launch_evt,
  input logic spi_sck,
  input logic spi_mosi
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES) + 1;

  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tick_cnt <= '0;
    else if (cmd_start) tick_cnt <= '0;
    else if (tick)      tick_cnt <= tick_cnt + 1'b1;
  end

  // R9: a start is never accepted while a command runs
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_start);

  // R3: an accepted start raises busy
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> busy);

  // R12: command end drops busy
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !busy);

  // R12: exactly 16 edges before the end of a command
  p_edge_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (tick_cnt == CW'(EDGES - 1)));

  // R8: no clock edges without a command
  p_no_tick_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tick);

  // R6: data out only moves on launch edges
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch_evt) |=> $stable(spi_mosi));

  // R12: clock only moves on divider ticks
  p_sck_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(spi_sck));

endmodule

bind spi_byte_master spi_bm_checker #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_w),
  .cmd_start  (cmd_start),
  .cmd_done   (cmd_done),
  .tick       (tick),
  .launch_evt (launch_evt),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi)
);

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_mosi_oe;
  logic        spi_miso;
  logic [1:0]  spi_cs;

  int checks = 0;
  int errors = 0;

  // bench slave state
  logic       armed = 1'b0;
  logic       b_rxf = 1'b0;
  logic       b_txf = 1'b0;
  logic       had_s = 1'b0;
  logic [7:0] slv = 8'h0;
  logic [7:0] cap = 8'h0;
  logic       miso_r = 1'b0;
  int         si = 0;
  int         edge_n = 0;

  assign spi_miso = miso_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_mosi_oe (spi_mosi_oe),
    .spi_miso    (spi_miso),
    .spi_cs      (spi_cs)
  );

  always @(spi_sck) begin : slave
    logic rising, smp, lch;
    if (armed) begin
      rising = spi_sck;
      smp = b_rxf ? !rising : rising;
      lch = b_txf ? !rising : rising;
      edge_n = edge_n + 1;
      if (smp) cap = {cap[6:0], spi_mosi};
      if (lch && had_s) si = si + 1;
      if (smp) had_s = 1'b1;
      miso_r = (si < 8) ? slv[7-si] : 1'b0;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic arm(input logic [7:0] sb, input logic [31:0] cfgw);
    b_rxf = cfgw[5]; b_txf = cfgw[4];
    slv = sb; si = 0; had_s = 1'b0; edge_n = 0; cap = 8'h0;
    miso_r = sb[7];
    armed = 1'b1;
  endtask

  // issue a control write with start bits and count busy cycles
  task automatic run_cmd(input logic [7:0] base, input logic [31:0] ctl, output int cyc);
    logic [31:0] st;
    reg_write(base + 8'h14, ctl);
    cyc = 0;
    reg_read(base, st);
    while (st[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      reg_read(base, st);
    end
    armed = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(8'h10, v); chk("R1 cfg0", v, 32'h153);
    reg_read(8'h50, v); chk("R1 cfg1", v, 32'h153);
    reg_read(8'h14, v); chk("R1 ctl0", v, 32'h9);
    reg_read(8'h54, v); chk("R1 ctl1", v, 32'h9);
    reg_read(8'h00, v); chk("R1 status", v, 32'h0);
    reg_read(8'hF0, v); chk("R1 arbiter", v, 32'h0);
    chk("R1 cs pins", spi_cs, 2'b11);
    chk("R1 sck", spi_sck, 1'b0);
    chk("R1 mosi_oe", spi_mosi_oe, 1'b0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    reg_write(8'h20, 32'h0000_00C3);
    reg_read(8'h20, v); chk("R2 data0", v, 32'hC3);
    reg_read(8'h60, v); chk("R2 data1 untouched", v, 32'h0);
    reg_read(8'h30, v); chk("R2 unmapped", v, 32'h0);
    reg_read(8'hA0, v); chk("R2 bank beyond selects", v, 32'h0);
    reg_write(8'hF0, 32'h8000_0000);
    reg_read(8'hF0, v); chk("R10 arbiter enable readback", v, 32'h8000_0000);
    reg_write(8'hF0, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int cyc;
    reg_write(8'h10, 32'h150);
    reg_write(8'h20, 32'hA5);
    reg_write(8'h14, 32'h0);
    chk("R10 cs0 asserted low", spi_cs, 2'b10);
    chk("R11 mosi_oe on", spi_mosi_oe, 1'b1);
    arm(8'h3C, 32'h150);
    run_cmd(8'h00, 32'h4, cyc);
    chk("R7 busy cycles p0", cyc, 16);
    chk("R3 bits on wire", cap, 8'hA5);
    chk("R12 edges", edge_n, 16);
    chk("R12 sck idle after", spi_sck, 1'b0);
    reg_read(8'h20, v); chk("R3 data unchanged", v, 32'hA5);
    reg_read(8'h14, v); chk("R9 start bits read 0", v, 32'h0);
  endtask

  task automatic t_mode(input logic [31:0] cfgw, input logic [7:0] txb, input logic [7:0] sb);
    logic [31:0] v;
    int cyc;
    logic msb;
    logic idle;
    msb = cfgw[8];
    idle = !cfgw[6];
    reg_write(8'h10, cfgw);
    reg_write(8'h20, {24'h0, txb});
    chk("R6 idle level", spi_sck, idle);
    arm(sb, cfgw);
    run_cmd(8'h00, 32'h2, cyc);
    chk("R7 busy cycles", cyc, 16 << cfgw[2:0]);
    chk("R5 wire order", cap, msb ? txb : rev8(txb));
    reg_read(8'h20, v);
    chk("R4 captured byte", v, {24'h0, msb ? sb : rev8(sb)});
    chk("R12 edges", edge_n, 16);
    chk("R6 idle level after", spi_sck, idle);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int cyc;
    reg_write(8'h10, 32'h152);
    reg_write(8'h20, 32'h5A);
    arm(8'hFF, 32'h152);
    reg_write(8'h14, 32'h4);
    repeat (10) @(negedge clk);
    reg_write(8'h14, 32'h2);
    run_cmd(8'h00, 32'h0, cyc);
    repeat (5) @(negedge clk);
    reg_read(8'h00, v); chk("R9 no second command", v, 32'h0);
    reg_read(8'h20, v); chk("R9 ignored read not captured", v, 32'h5A);
    chk("R9 single command edges", edge_n, 16);
    arm(8'h81, 32'h152);
    run_cmd(8'h00, 32'h6, cyc);
    reg_read(8'h20, v); chk("R9 both bits act as write", v, 32'h5A);
    chk("R9 both bits wire", cap, 8'h5A);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int cyc;
    reg_write(8'h10, 32'h157);
    reg_write(8'h20, 32'h33);
    arm(8'h00, 32'h157);
    reg_write(8'h14, 32'h4);
    repeat (200) @(negedge clk);
    reg_read(8'h00, v); chk("R8 still busy", v, 32'h1);
    chk("R8 no edges", edge_n, 0);
    chk("R8 sck parked", spi_sck, 1'b0);
    reg_write(8'h10, 32'h150);
    run_cmd(8'h00, 32'h0, cyc);
    chk("R8 resumed edges", edge_n, 16);
    chk("R8 resumed wire", cap, 8'h33);
  endtask

  task automatic t_sel1();
    logic [31:0] v;
    logic [31:0] d0;
    int cyc;
    reg_read(8'h20, d0);
    reg_write(8'hF0, 32'h8000_0002);
    chk("R10 cs1 active-high deasserted", spi_cs, 2'b00);
    reg_write(8'h14, 32'h9);
    reg_write(8'h54, 32'h0);
    chk("R10 cs pins swapped", spi_cs, 2'b11);
    reg_write(8'h50, 32'h163);
    reg_write(8'h60, 32'h0F);
    arm(8'hA7, 32'h163);
    run_cmd(8'h40, 32'h2, cyc);
    chk("R7 busy cycles p3", cyc, 128);
    reg_read(8'h60, v); chk("R2 sel1 capture", v, 32'hA7);
    reg_read(8'h20, v); chk("R2 sel0 data untouched", v, d0);
    chk("R2 sel1 wire", cap, 8'h0F);
    chk("R11 oe follows sel1", spi_mosi_oe, 1'b1);
    reg_write(8'h54, 32'h8);
    chk("R11 hiz on sel1", spi_mosi_oe, 1'b0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_write();
    t_mode(32'h051, 8'h96, 8'h3C);
    t_mode(32'h160, 8'h1E, 8'hC1);
    t_mode(32'h022, 8'h6B, 8'h5E);
    t_mode(32'h111, 8'hE2, 8'h96);
    t_busy();
    t_stop();
    t_sel1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule